// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. The walk uses a 10/10/12 split of the linear address. The base of the top-level table (the directory) comes from a global base register input. The walker fetches one directory entry through a request/response read port. If that entry is present, it fetches one entry from the page table the directory entry points to. It then joins the frame number from that second entry with the untouched 12-bit page offset.

A walk ends in one of two ways:
- a one-cycle `done` pulse with the physical address, or
- a one-cycle `fault` pulse, with the complete faulting linear address latched in a fault-address register.

Only one walk is in flight at a time. The walker lowers `req_ready` from the moment it accepts a request until the outcome pulse has been shown.

Top module: `pt_walker`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `done`, `fault` and `mem_rd_req` are 0.
- R2: The first read of a walk targets `{dir_base[31:12], va[31:22], 2'b00}`. Each entry is 4 bytes wide, and a directory holds 1024 of them.
- R3: When the directory entry is present, the second read targets `{dir_entry[31:12], va[21:12], 2'b00}`.
- R4: When both entries are present, `done` carries `phys_addr = {table_entry[31:12], va[11:0]}`.
- R5: Bit 0 of an entry is the present flag, and entry bits [11:1] have no effect. A directory entry with bit 0 clear ends the walk with `fault` and issues no second read.
- R6: A page-table entry with bit 0 clear ends the walk with `fault`.
- R7: On a fault, `fault_addr` takes the full linear address of that walk. It holds that value through later successful walks until the next fault.
- R8: Every accepted request yields exactly one one-cycle pulse on exactly one of `done` or `fault`, and `req_ready` is 1 again in the cycle after that pulse.
- R9: While a walk is in progress, `req_ready` is 0 and requests on `req_valid` are ignored. `dir_base` is sampled only when a request is accepted, so later changes to it do not affect that walk.
- R10: Each level issues exactly one one-cycle `mem_rd_req` pulse. The walker then waits any number of cycles for `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request; accepted when `req_ready` is 1 |
| req_addr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| dir_base | input | 32 | Directory base register; bits [31:12] are used |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: translation complete |
| phys_addr | output | 32 | Translated physical address, valid with `done` |
| fault | output | 1 | One-cycle pulse: walk hit a not-present entry |
| fault_addr | output | 32 | Linear address of the most recent faulting walk |

## Verification
The assertions assume that the memory side raises `mem_rsp_valid` only while a read is outstanding. That means at least one cycle after the `mem_rd_req` pulse and at most once per pulse. The bench's memory model arms its reply only when it sees a request, and then answers after a rotating delay of one to four cycles.

Translation contents are computed arithmetically from the address being read. Present flags follow fixed modulo patterns, and the unused entry bits are filled with non-zero values. Extra `req_valid` pulses and changes to `dir_base` are injected only while a walk is in progress.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_addr,
  output logic            req_ready,
  input  logic [VA_W-1:0] dir_base,
  output logic            mem_rd_req,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            done,
  output logic [VA_W-1:0] phys_addr,
  output logic            fault,
  output logic [VA_W-1:0] fault_addr
);
  localparam int FRAME_W = VA_W - OFS_W;
  localparam int ENT_SH  = 2;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_PTE, S_DONE, S_FAULT} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic [FRAME_W-1:0] base_q;
  logic              pend;

  wire               present   = mem_rsp_data[0];
  wire [FRAME_W-1:0] rsp_frame = mem_rsp_data[VA_W-1:OFS_W];
  wire [DIR_W-1:0]   dir_idx   = va_q[VA_W-1 -: DIR_W];
  wire [TBL_W-1:0]   tbl_idx   = va_q[OFS_W +: TBL_W];
  wire [OFS_W-1:0]   dir_off   = OFS_W'({dir_idx, {ENT_SH{1'b0}}});
  wire [OFS_W-1:0]   tbl_off   = OFS_W'({tbl_idx, {ENT_SH{1'b0}}});
  wire               walking   = (st == S_DIR) || (st == S_PTE);
  wire               take      = walking && pend && mem_rsp_valid;

  assign req_ready   = (st == S_IDLE);
  assign done        = (st == S_DONE);
  assign fault       = (st == S_FAULT);
  assign mem_rd_req  = walking && !pend;
  assign mem_rd_addr = {base_q, (st == S_DIR) ? dir_off : tbl_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pend       <= 1'b0;
      va_q       <= '0;
      base_q     <= '0;
      phys_addr  <= '0;
      fault_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_addr;
          base_q <= dir_base[VA_W-1:OFS_W];
          st     <= S_DIR;
        end
        S_DIR, S_PTE: begin
          if (mem_rd_req) pend <= 1'b1;
          if (take) begin
            pend <= 1'b0;
            if (!present) begin
              fault_addr <= va_q;
              st         <= S_FAULT;
            end else if (st == S_DIR) begin
              base_q <= rsp_frame;
              st     <= S_PTE;
            end else begin
              phys_addr <= {rsp_frame, va_q[OFS_W-1:0]};
              st        <= S_DONE;
            end
          end
        end
        S_DONE, S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_no_dual_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  assert_ready_after_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> req_ready);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_read_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);
  assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  assert_read_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && !take && !(req_valid && req_ready)) |=> $stable(mem_rd_addr));
  assert_fault_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(walking && take && !present) |=> $stable(fault_addr));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic [31:0] dir_base = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] phys_addr;
  logic        fault;
  logic [31:0] fault_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] model_base = '0;
  logic [31:0] last_fault_va = '0;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .dir_base(dir_base), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .phys_addr(phys_addr),
    .fault(fault), .fault_addr(fault_addr)
  );

  function automatic logic [31:0] mem_value(input logic [31:0] a);
    logic [9:0] hi, lo;
    hi = a[21:12];
    lo = a[11:2];
    if (a[31:12] == model_base[31:12])
      return {20'h40000 + 20'(lo), 11'h5A5, (lo % 5) != 4};
    else if (a[31:22] == 10'h100)
      return {({hi, lo} ^ 20'h5A5A5), 11'h3C3, ((32'(hi) + 32'(lo)) % 3) != 0};
    else
      return 32'hDEAD_BEE0;
  endfunction

  int lat_sel = 0;
  int cnt = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
    if (mem_rd_req) begin
      pend_addr <= mem_rd_addr;
      cnt <= lat_sel + 1;
      lat_sel <= (lat_sel + 1) % 4;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_value(pend_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit poke, input bit move_base);
    logic [9:0] d, t;
    logic [31:0] exp_dir, exp_pte, exp_phys;
    logic [31:0] rd0, rd1, got_phys;
    bit pde_p, pte_p;
    int n_rd, n_done, n_fault, idle;
    d = va[31:22];
    t = va[21:12];
    pde_p = (d % 5) != 4;
    pte_p = ((32'(d) + 32'(t)) % 3) != 0;
    exp_dir = {model_base[31:12], d, 2'b00};
    exp_pte = {20'h40000 + 20'(d), t, 2'b00};
    exp_phys = {({d, t} ^ 20'h5A5A5), va[11:0]};
    n_rd = 0; n_done = 0; n_fault = 0; idle = 0;
    rd0 = '0; rd1 = '0; got_phys = '0;
    @(negedge clk);
    chk(req_ready, "R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (move_base) dir_base = 32'h0BAD_0000;
    for (int c = 0; c < 60 && idle < 4; c++) begin
      if (poke && c == 1) begin req_valid = 1'b1; req_addr = ~va; end
      if (poke && c == 3) req_valid = 1'b0;
      if (mem_rd_req) begin
        if (n_rd == 0) rd0 = mem_rd_addr; else rd1 = mem_rd_addr;
        n_rd++;
      end
      if (done) begin n_done++; got_phys = phys_addr; end
      if (fault) n_fault++;
      if (n_done + n_fault > 0) idle++;
      @(negedge clk);
    end
    dir_base = model_base;
    chk(rd0 == exp_dir, "R2 directory read address", rd0, exp_dir);
    if (pde_p) begin
      chk(n_rd == 2, "R10 two reads per full walk", 32'(n_rd), 32'd2);
      chk(rd1 == exp_pte, "R3 table read address", rd1, exp_pte);
    end else begin
      chk(n_rd == 1, "R5 no table read after absent directory entry", 32'(n_rd), 32'd1);
    end
    chk(n_done + n_fault == 1, "R8 one outcome pulse", 32'(n_done + n_fault), 32'd1);
    if (pde_p && pte_p) begin
      chk(n_done == 1, "R4 done for present entries", 32'(n_done), 32'd1);
      chk(got_phys == exp_phys, "R4 physical address", got_phys, exp_phys);
      chk(fault_addr == last_fault_va, "R7 fault address held", fault_addr, last_fault_va);
    end else begin
      chk(n_fault == 1, pde_p ? "R6 table fault" : "R5 directory fault", 32'(n_fault), 32'd1);
      chk(fault_addr == va, "R7 fault address", fault_addr, va);
      last_fault_va = va;
    end
    if (poke) chk(req_ready && n_rd <= 2, "R9 request during walk ignored", 32'(n_rd), 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_base = 32'h0001_2000;
    dir_base = model_base;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready at reset", 32'(req_ready), 32'd1);
    chk(!done && !fault, "R1 no outcome at reset", {30'd0, done, fault}, 32'd0);
    chk(!mem_rd_req, "R1 no read at reset", 32'(mem_rd_req), 32'd0);
    rst_n = 1'b1;
    for (int b = 0; b < 2; b++) begin
      model_base = (b == 0) ? 32'h0001_2000 : 32'h7FFF_F000;
      dir_base = model_base;
      for (int d = 0; d < 1024; d++) begin
        for (int k = 0; k < 2; k++) begin
          logic [31:0] va;
          va = {10'(d), 10'((d * 37 + k * 511) % 1024), 12'((d * 13 + k * 101) % 4096)};
          walk(va, ((d + k) % 7) == 0, ((d + k) % 11) == 0);
        end
      end
    end
    walk(32'hFFFF_FFFF, 1'b1, 1'b1);
    walk(32'h0000_0000, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule